// File: doc/BRIEF.md
# Synchronized Cache Line Access Arbiter

This block sits beside the shared snoop bus of a small multi-core cluster and gives hardware mutual exclusion on cache lines. A core that accesses memory presents a line address and a one-bit flag from its translation entry that says the page is synchronized. Unflagged accesses go through untouched. For a flagged access the block looks through every core's ownership table. If another core already holds the line, the requester gets a dedicated trap. If no other core holds it, the access is granted, the line is recorded as owned by the requester, and that core's critical-section status bit is set.

A core releases ownership in one of two ways. It can drop one line with a single-line evict, which is how the entry line of a finished synchronized routine is unlocked. It can also drop every line it holds at once when it gives up the CPU. Each core has a saturating counter of failed attempts, which a scheduler can read to favour cores that keep losing. External interrupts aimed at a core that is inside a critical section are held back until that core's status bit clears.

Top module: `sync_line_arbiter`

## Requirements
- R1: While `rst` is high and in the first cycle after it, every output is zero.
- R2: A valid request with `req_sync` low is answered with `grant` high one cycle later. It allocates nothing and leaves the failure counter unchanged.
- R3: A valid request with `req_sync` high for a line that no other core holds, made while the requester has a free slot, produces `grant` one cycle later. The line is recorded and that core's `in_cs` goes high on the same edge.
- R4: A valid synchronized request for a line that another core holds produces `trap` one cycle later. Nothing is allocated and `grant` stays low. `grant` and `trap` are never high together for one core.
- R5: Exclusion is per line address. Different cores may hold different lines in the same cycle, including adjacent lines of one page.
- R6: When several cores request the same free line in one cycle, they are judged in round-robin order. The order starts at the pointer, which is 0 after reset and advances by one (mod NCORE) in every cycle with any valid request. The first requester in that order wins and the others are trapped.
- R7: Each core holds at most SLOTS (4) lines. A synchronized request for a new line with all slots used is trapped. A repeat request for a line the core already holds is granted and uses no new slot.
- R8: `evict_all` clears every line of that core before the same cycle's requests are judged. If the core is not granted a synchronized line in that cycle, its `in_cs` is low one cycle later.
- R9: `evict_one` with `evict_line` releases only the matching line of that core, before the same cycle's requests are judged.
- R10: Each trap adds one to that core's `fail_cnt` field (CNT_W bits, core c at bits c*CNT_W). The count saturates at 2^CNT_W-1.
- R11: An `irq_in` pulse for a core is held pending while that core's `in_cs` is high. At each edge where `in_cs` is low, any pending or incoming interrupt appears as a one-cycle pulse on `irq_out` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NCORE | Access request per core |
| req_sync | input | NCORE | Synchronized-page flag per request |
| req_line | input | NCORE*LINE_W | Line address per core |
| evict_all | input | NCORE | Release all lines of the core (context switch) |
| evict_one | input | NCORE | Release one line of the core |
| evict_line | input | NCORE*LINE_W | Line released by evict_one |
| irq_in | input | NCORE | External interrupt per core |
| grant | output | NCORE | Access granted |
| trap | output | NCORE | Synchronized-access trap |
| in_cs | output | NCORE | Critical-section status bit |
| irq_out | output | NCORE | Interrupt delivered to the core |
| fail_cnt | output | NCORE*CNT_W | Saturating failure counts |

## Verification
A stale or missing entry in an ownership table shows on the very next synchronized request for that line. A lost entry lets a second core be granted where it should be trapped. A leftover entry traps a core that should win, and it keeps `in_cs` high after a release. A drifting round-robin pointer shows up the first time several cores contend for one line. Because the bench's model is compared with every output on every clock, such faults are reported in the cycle where they first change a grant, trap, status bit, interrupt or count.

// File: rtl/sla_pkg.sv
package sla_pkg;
  function automatic int wrap_next(int v, int n);
    return (v == n - 1) ? 0 : v + 1;
  endfunction
endpackage

// File: rtl/sla_sat_counter.sv
module sla_sat_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else if (inc && count != TOP) count <= count + 1'b1;
  end

  // R10
  sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (count == TOP) |=> (count == TOP));
endmodule

// File: rtl/sla_irq_hold.sv
module sla_irq_hold (
  input  logic clk,
  input  logic rst,
  input  logic irq_in,
  input  logic busy,
  output logic irq_out
);
  logic pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= 1'b0;
      irq_out <= 1'b0;
    end else if (!busy) begin
      irq_out <= pend_q | irq_in;
      pend_q  <= 1'b0;
    end else begin
      irq_out <= 1'b0;
      pend_q  <= pend_q | irq_in;
    end
  end

  // R11
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> $past(!busy));
endmodule

// File: rtl/sync_line_arbiter.sv
module sync_line_arbiter #(
  parameter int NCORE  = 4,
  parameter int LINE_W = 16,
  parameter int SLOTS  = 4,
  parameter int CNT_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NCORE-1:0]        req_valid,
  input  logic [NCORE-1:0]        req_sync,
  input  logic [NCORE*LINE_W-1:0] req_line,
  input  logic [NCORE-1:0]        evict_all,
  input  logic [NCORE-1:0]        evict_one,
  input  logic [NCORE*LINE_W-1:0] evict_line,
  input  logic [NCORE-1:0]        irq_in,
  output logic [NCORE-1:0]        grant,
  output logic [NCORE-1:0]        trap,
  output logic [NCORE-1:0]        in_cs,
  output logic [NCORE-1:0]        irq_out,
  output logic [NCORE*CNT_W-1:0]  fail_cnt
);
  import sla_pkg::*;

  localparam int RR_W = (NCORE > 1) ? $clog2(NCORE) : 1;

  logic [SLOTS-1:0]  vld_q [NCORE];
  logic [SLOTS-1:0]  vld_n [NCORE];
  logic [LINE_W-1:0] lin_q [NCORE][SLOTS];
  logic [LINE_W-1:0] lin_n [NCORE][SLOTS];
  logic [NCORE-1:0]  gnt_n, trp_n, cs_n;
  logic [RR_W-1:0]   rr_q;

  // Releases first, then requests in round-robin order on the updated tables
  always_comb begin
    int c, fidx;
    logic other, mine, hasfree;
    logic [LINE_W-1:0] ln;
    c = 0; fidx = 0; other = 1'b0; mine = 1'b0; hasfree = 1'b0; ln = '0;
    gnt_n = '0;
    trp_n = '0;
    for (int k = 0; k < NCORE; k++) begin
      vld_n[k] = vld_q[k];
      for (int s = 0; s < SLOTS; s++) begin
        lin_n[k][s] = lin_q[k][s];
        if (evict_all[k] ||
            (evict_one[k] && lin_q[k][s] == evict_line[k*LINE_W +: LINE_W]))
          vld_n[k][s] = 1'b0;
      end
    end
    for (int o = 0; o < NCORE; o++) begin
      c = (int'(rr_q) + o) % NCORE;
      ln = req_line[c*LINE_W +: LINE_W];
      other = 1'b0; mine = 1'b0; hasfree = 1'b0; fidx = 0;
      for (int k = 0; k < NCORE; k++)
        for (int s = 0; s < SLOTS; s++)
          if (vld_n[k][s] && lin_n[k][s] == ln) begin
            if (k == c) mine = 1'b1;
            else        other = 1'b1;
          end
      for (int s = SLOTS - 1; s >= 0; s--)
        if (!vld_n[c][s]) begin
          hasfree = 1'b1;
          fidx = s;
        end
      if (req_valid[c]) begin
        if (!req_sync[c] || (!other && mine)) gnt_n[c] = 1'b1;
        else if (!other && hasfree) begin
          gnt_n[c] = 1'b1;
          vld_n[c][fidx] = 1'b1;
          lin_n[c][fidx] = ln;
        end else trp_n[c] = 1'b1;
      end
    end
    for (int k = 0; k < NCORE; k++) cs_n[k] = |vld_n[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NCORE; k++) begin
        vld_q[k] <= '0;
        for (int s = 0; s < SLOTS; s++) lin_q[k][s] <= '0;
      end
      grant <= '0;
      trap  <= '0;
      in_cs <= '0;
      rr_q  <= '0;
    end else begin
      for (int k = 0; k < NCORE; k++) begin
        vld_q[k] <= vld_n[k];
        for (int s = 0; s < SLOTS; s++) lin_q[k][s] <= lin_n[k][s];
      end
      grant <= gnt_n;
      trap  <= trp_n;
      in_cs <= cs_n;
      if (|req_valid) rr_q <= RR_W'(wrap_next(int'(rr_q), NCORE));
    end
  end

  genvar g;
  generate
    for (g = 0; g < NCORE; g++) begin : g_core
      sla_sat_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .inc(trp_n[g]),
        .count(fail_cnt[g*CNT_W +: CNT_W]));
      sla_irq_hold u_irq (
        .clk(clk), .rst(rst), .irq_in(irq_in[g]), .busy(in_cs[g]),
        .irq_out(irq_out[g]));

      // R2
      unsync_grant_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid[g] && !req_sync[g]) |=> grant[g]);
      // R8
      evict_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (evict_all[g] && !(req_valid[g] && req_sync[g])) |=> !in_cs[g]);
    end
  endgenerate

  // R4
  one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
    (grant & trap) == '0);

  logic dup;
  always_comb begin
    dup = 1'b0;
    for (int a = 0; a < NCORE; a++)
      for (int b = 0; b < NCORE; b++)
        for (int i = 0; i < SLOTS; i++)
          for (int j = 0; j < SLOTS; j++)
            if (a != b && vld_q[a][i] && vld_q[b][j] && lin_q[a][i] == lin_q[b][j])
              dup = 1'b1;
  end

  // R4
  excl_chk: assert property (@(posedge clk) disable iff (rst) !dup);
endmodule

// File: tb/sync_line_arbiter_tb.sv
module sync_line_arbiter_tb;
  localparam int N = 4, LW = 16, SL = 4, CW = 8;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0, rst = 1'b1;
  always #2 clk = ~clk;

  logic [N-1:0] rv, rs, ea, eo, iq;
  int rl [N];
  int el [N];
  logic [N*LW-1:0] req_line, evict_line;
  logic [N-1:0] grant, trap, in_cs, irq_out;
  logic [N*CW-1:0] fail_cnt;

  always_comb
    for (int c = 0; c < N; c++) begin
      req_line[c*LW +: LW]   = LW'(rl[c]);
      evict_line[c*LW +: LW] = LW'(el[c]);
    end

  sync_line_arbiter #(.NCORE(N), .LINE_W(LW), .SLOTS(SL), .CNT_W(CW)) u_dut (
    .clk(clk), .rst(rst), .req_valid(rv), .req_sync(rs), .req_line(req_line),
    .evict_all(ea), .evict_one(eo), .evict_line(evict_line), .irq_in(iq),
    .grant(grant), .trap(trap), .in_cs(in_cs), .irq_out(irq_out),
    .fail_cnt(fail_cnt));

  // behavioural reference state
  bit mv [N][SL];
  int ml [N][SL];
  int mfail [N];
  bit mpend [N];
  bit [N-1:0] eg, et, ecs, eirq;
  int rr;
  int vectors = 0, errors = 0;
  string tag = "R1";

  task automatic model_reset();
    for (int c = 0; c < N; c++) begin
      for (int s = 0; s < SL; s++) begin mv[c][s] = 0; ml[c][s] = 0; end
      mfail[c] = 0; mpend[c] = 0;
    end
    eg = 0; et = 0; ecs = 0; eirq = 0; rr = 0;
  endtask

  task automatic model_step();
    bit held;
    for (int c = 0; c < N; c++)
      for (int s = 0; s < SL; s++)
        if (ea[c] || (eo[c] && ml[c][s] == el[c])) mv[c][s] = 0;
    eg = 0; et = 0;
    for (int o = 0; o < N; o++) begin
      int c, freeslot;
      bit other, mine;
      c = (rr + o) % N;
      if (!rv[c]) continue;
      if (!rs[c]) begin eg[c] = 1; continue; end
      other = 0; mine = 0; freeslot = -1;
      for (int k = 0; k < N; k++)
        for (int s = 0; s < SL; s++)
          if (mv[k][s] && ml[k][s] == rl[c]) begin
            if (k == c) mine = 1; else other = 1;
          end
      for (int s = SL - 1; s >= 0; s--) if (!mv[c][s]) freeslot = s;
      if (other) et[c] = 1;
      else if (mine) eg[c] = 1;
      else if (freeslot >= 0) begin
        eg[c] = 1; mv[c][freeslot] = 1; ml[c][freeslot] = rl[c];
      end else et[c] = 1;
    end
    if (rv != 0) rr = (rr + 1) % N;
    for (int c = 0; c < N; c++) begin
      bit p;
      p = mpend[c] | iq[c];
      if (!ecs[c]) begin eirq[c] = p; mpend[c] = 0; end
      else begin eirq[c] = 0; mpend[c] = p; end
      if (et[c] && mfail[c] < CMAX) mfail[c]++;
      held = 0;
      for (int s = 0; s < SL; s++) held |= mv[c][s];
      ecs[c] = held;
    end
  endtask

  task automatic cmp(string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    cmp("grant", int'(grant), int'(eg));
    cmp("trap", int'(trap), int'(et));
    cmp("in_cs", int'(in_cs), int'(ecs));
    cmp("irq_out", int'(irq_out), int'(eirq));
    for (int c = 0; c < N; c++) cmp("fail_cnt", int'(fail_cnt[c*CW +: CW]), mfail[c]);
  endtask

  task automatic idle();
    rv = 0; rs = 0; ea = 0; eo = 0; iq = 0;
    for (int c = 0; c < N; c++) begin rl[c] = 0; el[c] = 0; end
  endtask

  task automatic step();
    @(posedge clk);
    if (rst) model_reset(); else model_step();
    @(negedge clk);
    compare_all();
    idle();
  endtask

  task automatic req(int c, bit sync, int line);
    rv[c] = 1; rs[c] = sync; rl[c] = line;
  endtask

  initial begin
    idle();
    model_reset();
    // R1: outputs during and right after reset
    repeat (3) step();
    @(negedge clk); rst = 1'b0;
    step();

    tag = "R3"; req(1, 1, 7); step();
    tag = "R2"; req(0, 0, 7); step();
    req(3, 0, 5); step();
    tag = "R4"; req(2, 1, 7); step();
    tag = "R5"; req(0, 1, 'h100); req(2, 1, 'h101); step();
    tag = "R6";
    for (int r = 0; r < 5; r++) begin
      for (int c = 0; c < N; c++) req(c, 1, 'h200 + r);
      step();
      if (r == 2) begin rv[0] = 1; rs[0] = 0; step(); end
    end
    tag = "R7";
    for (int i = 0; i < 4; i++) begin req(3, 1, 'h300 + i); step(); end
    req(3, 1, 'h304); step();
    req(3, 1, 'h301); step();
    tag = "R9"; eo[3] = 1; el[3] = 'h301; step();
    req(0, 1, 'h301); step();
    req(3, 1, 'h300); step();
    tag = "R8"; ea[3] = 1; req(3, 1, 'h305); step();
    ea[3] = 1; step();
    ea[1] = 1; step();
    req(2, 1, 7); step();
    tag = "R11"; iq[2] = 1; step();
    iq[0] = 1; step();
    step(); step();
    ea[0] = 1; step();
    step(); step();
    tag = "R10"; req(1, 1, 'h400); step();
    for (int i = 0; i < 262; i++) begin req(3, 1, 'h400); step(); end
    tag = "R6";
    for (int i = 0; i < 400; i++) begin
      for (int c = 0; c < N; c++) begin
        if ($urandom_range(0, 1) == 1) req(c, $urandom_range(0, 3) != 0, $urandom_range(0, 9));
        if ($urandom_range(0, 15) == 0) ea[c] = 1;
        if ($urandom_range(0, 7) == 0) begin eo[c] = 1; el[c] = $urandom_range(0, 9); end
        if ($urandom_range(0, 9) == 0) iq[c] = 1;
      end
      step();
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule